// File: doc/BRIEF.md
# Segment Protection and Page Translation Unit

This unit sits in front of a memory port and decides, for each access, whether the access may proceed and to which physical address it goes. The requester presents an address to which the segment base has already been added, the access size in bytes, a write flag, an execute flag and the index of the segment the access goes through. The unit reads that segment's base, limit and attribute bits, along with four mode control bits. It then either reports a general-protection fault or produces a physical address. That address comes from a small fully associative page table or is the input address passed straight through.

Mode selection works in three layers. With protection disabled, every address passes unchanged. With protection enabled, the segment permission and limit checks run unless long mode is active and the code segment is marked 64-bit. With paging enabled, every access that survives the checks is translated through the page table using 4 KiB pages. The table is loaded through a write port that fills entries round-robin and updates an entry in place when its page is already present. A separate strobe flushes the entry for one page. Each result is registered and appears one cycle after the request strobe.

Top module: `segxlat_top`

## Requirements
- R1: While reset is asserted and after it is released, rsp_valid is 0, rsp_fault is 0 and rsp_paddr is 0. rsp_valid is 1 in exactly the cycle after a cycle with req_valid=1. rsp_fault uses the codes 0 = none, 1 = general protection and 2 = translation miss, and rsp_paddr is 0 whenever rsp_fault is not 0.
- R2: With prot_en=0, the response carries fault 0 and rsp_paddr equal to req_addr, whatever the segment attributes, the write/execute flags or paging_en.
- R3: With prot_en=1, long_act=1 and cs_long=1, no segment check is made and no general-protection fault arises. If either of those two flags is 0, the checks run.
- R4: With checks running, a write (req_write=1) to a segment whose writable bit is 0 faults with code 1. A read (req_write=0, req_exec=0) from a segment whose readable bit is 0 faults with code 1. An execute access ignores the readable bit.
- R5: For an expand-up segment whose limit is at or above its base, the access faults (code 1) when limit < req_addr + req_size. The sum is formed one bit wider than the address.
- R6: For an expand-up segment whose limit is below its base, the access faults only when limit < req_addr + req_size and req_addr < base.
- R7: For an expand-down segment whose limit is at or above its base, the access faults when req_addr <= limit and req_addr + req_size >= base.
- R8: For an expand-down segment whose limit is below its base, the access faults when req_addr <= limit or req_addr + req_size >= base.
- R9: With checks running, a segment index of NUM_SEG or above (6 or 7 by default) faults with code 1.
- R10: With prot_en=1 and no general-protection fault, paging_en=0 gives rsp_paddr = req_addr. With paging_en=1, a table hit gives rsp_paddr = {frame, req_addr[11:0]}, and a miss gives code 2. A general-protection fault takes priority over the table lookup.
- R11: A table write whose page is not present goes to the slot under a round-robin pointer. The pointer starts at slot 0, steps by one per such write and wraps after slot 7, so the write replaces whatever that slot held. A write whose page is already present replaces that entry's frame and leaves the pointer unchanged.
- R12: A flush strobe invalidates the entry holding the given page and leaves all other entries intact.
- R13: Table writes and flushes take effect at the clock edge that ends their cycle, so a request in the same cycle sees the table as it was before. A write and a flush of the same page in one cycle leave the page valid with the newly written frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Address with segment base already added |
| req_size | input | SIZE_W | Access size in bytes |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_seg | input | IDX_W | Segment index |
| prot_en | input | 1 | Protection enable (0 = real mode) |
| paging_en | input | 1 | Paging enable |
| long_act | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment 64-bit attribute |
| seg_base | input | NUM_SEG*ADDR_W | Packed per-segment bases, segment s at bits s*ADDR_W upward |
| seg_limit | input | NUM_SEG*ADDR_W | Packed per-segment limits, same packing |
| seg_wr_ok | input | NUM_SEG | Per-segment writable bit |
| seg_rd_ok | input | NUM_SEG | Per-segment readable bit |
| seg_grow_down | input | NUM_SEG | Per-segment expand-down bit |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_vpn | input | ADDR_W-12 | Virtual page number to load |
| tbl_wr_pfn | input | ADDR_W-12 | Page frame to load |
| tbl_inv_en | input | 1 | Flush strobe |
| tbl_inv_vpn | input | ADDR_W-12 | Virtual page number to flush |
| rsp_valid | output | 1 | Result valid, one cycle after req_valid |
| rsp_fault | output | 2 | Fault code: 0 none, 1 protection, 2 miss |
| rsp_paddr | output | ADDR_W | Physical address, 0 on fault |

## Verification
Two functions can meet in one cycle: a lookup for a request, and a table write or flush of the same page. The bench provokes this by raising req_valid together with tbl_wr_en or tbl_inv_en in a single cycle. It expects the response to reflect the old table contents: a miss for the page being written, and a hit for the page being flushed. It then issues a second request and expects the new contents. A write and a flush of the same page in one cycle are also driven together, and the following lookup must return the written frame.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;

    // Comparison width: wide enough for a 64-bit address plus carry
    localparam int CMP_W = 65;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_MISS = 2'd2
    } fault_e;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
        logic grow_down;
    } seg_attr_t;

    // Limit rule for one segment; operands zero-extended to CMP_W
    function automatic logic range_fault(
        input logic             down,
        input logic [CMP_W-1:0] base,
        input logic [CMP_W-1:0] limit,
        input logic [CMP_W-1:0] first,
        input logic [CMP_W-1:0] stop
    );
        logic wrapped;
        wrapped = limit < base;
        if (!down)
            range_fault = wrapped ? ((limit < stop) && (first < base))
                                  : (limit < stop);
        else
            range_fault = wrapped ? ((first <= limit) || (stop >= base))
                                  : ((first <= limit) && (stop >= base));
    endfunction

endpackage

// File: rtl/segxlat_segchk.sv
module segxlat_segchk
    import segxlat_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SIZE_W  = 4,
    parameter int NUM_SEG = 6,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [SIZE_W-1:0]         size,
    input  logic                      write,
    input  logic                      exec,
    input  logic [IDX_W-1:0]          idx,
    input  logic [NUM_SEG*ADDR_W-1:0] base_flat,
    input  logic [NUM_SEG*ADDR_W-1:0] limit_flat,
    input  logic [NUM_SEG-1:0]        wr_ok,
    input  logic [NUM_SEG-1:0]        rd_ok,
    input  logic [NUM_SEG-1:0]        grow_down,
    output logic                      gp
);

    logic [CMP_W-1:0] a_x, end_x, b_x, l_x;
    seg_attr_t        attr;
    logic             idx_ok;
    logic             perm_bad;

    always_comb begin
        b_x    = '0;
        l_x    = '0;
        attr   = '0;
        idx_ok = 1'b0;
        for (int s = 0; s < NUM_SEG; s++) begin
            if (IDX_W'(s) == idx) begin
                idx_ok         = 1'b1;
                b_x            = CMP_W'(base_flat[s*ADDR_W +: ADDR_W]);
                l_x            = CMP_W'(limit_flat[s*ADDR_W +: ADDR_W]);
                attr.wr_ok     = wr_ok[s];
                attr.rd_ok     = rd_ok[s];
                attr.grow_down = grow_down[s];
            end
        end
        a_x      = CMP_W'(addr);
        end_x    = a_x + CMP_W'(size);
        perm_bad = (write && !attr.wr_ok) || (!write && !exec && !attr.rd_ok);
        gp       = !idx_ok || perm_bad ||
                   range_fault(attr.grow_down, b_x, l_x, a_x, end_x);
    end

endmodule

// File: rtl/segxlat_ptab.sv
module segxlat_ptab #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] pfn
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld;
    logic [VPN_W-1:0]   tag [ENTRIES];
    logic [PFN_W-1:0]   frm [ENTRIES];
    logic [PTR_W-1:0]   ptr;
    logic [ENTRIES-1:0] look_m, wr_m, inv_m, wr_sel;
    logic               wr_present;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign look_m[g] = vld[g] && (tag[g] == look_vpn);
        assign wr_m[g]   = vld[g] && (tag[g] == wr_vpn);
        assign inv_m[g]  = vld[g] && (tag[g] == inv_vpn);
    end

    assign wr_present = |wr_m;

    always_comb begin
        for (int e = 0; e < ENTRIES; e++)
            wr_sel[e] = wr_en && (wr_present ? wr_m[e] : (ptr == PTR_W'(e)));
    end

    always_comb begin
        pfn = '0;
        for (int e = 0; e < ENTRIES; e++)
            if (look_m[e]) pfn = pfn | frm[e];
    end
    assign hit = |look_m;

    // Valid bits: flush first, write after so a write wins on the same page
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            ptr <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (inv_en && inv_m[e]) vld[e] <= 1'b0;
                if (wr_sel[e])          vld[e] <= 1'b1;
            end
            if (wr_en && !wr_present)
                ptr <= (ptr == PTR_W'(ENTRIES-1)) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (wr_sel[e]) begin
                tag[e] <= wr_vpn;
                frm[e] <= wr_pfn;
            end
        end
    end

    // R11: in-place update keeps every page in at most one slot
    p_single_hit_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_m));

    // R12: without a flush the number of live entries never drops
    p_flush_only_shrinks_r12: assert property (@(posedge clk) disable iff (rst)
        !inv_en |=> ($countones(vld) >= $past($countones(vld))));

endmodule

// File: rtl/segxlat_top.sv
module segxlat_top
    import segxlat_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 4,
    parameter int NUM_SEG   = 6,
    parameter int IDX_W     = $clog2(NUM_SEG + 1),
    parameter int ENTRIES   = 8,
    parameter int PAGE_BITS = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [SIZE_W-1:0]             req_size,
    input  logic                          req_write,
    input  logic                          req_exec,
    input  logic [IDX_W-1:0]              req_seg,
    input  logic                          prot_en,
    input  logic                          paging_en,
    input  logic                          long_act,
    input  logic                          cs_long,
    input  logic [NUM_SEG*ADDR_W-1:0]     seg_base,
    input  logic [NUM_SEG*ADDR_W-1:0]     seg_limit,
    input  logic [NUM_SEG-1:0]            seg_wr_ok,
    input  logic [NUM_SEG-1:0]            seg_rd_ok,
    input  logic [NUM_SEG-1:0]            seg_grow_down,
    input  logic                          tbl_wr_en,
    input  logic [ADDR_W-PAGE_BITS-1:0]   tbl_wr_vpn,
    input  logic [ADDR_W-PAGE_BITS-1:0]   tbl_wr_pfn,
    input  logic                          tbl_inv_en,
    input  logic [ADDR_W-PAGE_BITS-1:0]   tbl_inv_vpn,
    output logic                          rsp_valid,
    output logic [1:0]                    rsp_fault,
    output logic [ADDR_W-1:0]             rsp_paddr
);

    localparam int VPN_W = ADDR_W - PAGE_BITS;

    logic              seg_gp, chk_on, tab_hit;
    logic [VPN_W-1:0]  tab_pfn;
    fault_e            nxt_flt, flt_q;
    logic [ADDR_W-1:0] nxt_pa, pa_q;
    logic              vld_q;

    segxlat_segchk #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .NUM_SEG(NUM_SEG),
        .IDX_W  (IDX_W)
    ) u_segchk (
        .addr      (req_addr),
        .size      (req_size),
        .write     (req_write),
        .exec      (req_exec),
        .idx       (req_seg),
        .base_flat (seg_base),
        .limit_flat(seg_limit),
        .wr_ok     (seg_wr_ok),
        .rd_ok     (seg_rd_ok),
        .grow_down (seg_grow_down),
        .gp        (seg_gp)
    );

    segxlat_ptab #(
        .ENTRIES(ENTRIES),
        .VPN_W  (VPN_W),
        .PFN_W  (VPN_W)
    ) u_ptab (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr_en),
        .wr_vpn  (tbl_wr_vpn),
        .wr_pfn  (tbl_wr_pfn),
        .inv_en  (tbl_inv_en),
        .inv_vpn (tbl_inv_vpn),
        .look_vpn(req_addr[ADDR_W-1:PAGE_BITS]),
        .hit     (tab_hit),
        .pfn     (tab_pfn)
    );

    assign chk_on = prot_en && !(long_act && cs_long);

    always_comb begin
        nxt_flt = FLT_NONE;
        nxt_pa  = req_addr;
        if (prot_en) begin
            if (chk_on && seg_gp) begin
                nxt_flt = FLT_GP;
                nxt_pa  = '0;
            end else if (paging_en) begin
                if (tab_hit) begin
                    nxt_pa = {tab_pfn, req_addr[PAGE_BITS-1:0]};
                end else begin
                    nxt_flt = FLT_MISS;
                    nxt_pa  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            flt_q <= FLT_NONE;
            pa_q  <= '0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) begin
                flt_q <= nxt_flt;
                pa_q  <= nxt_pa;
            end
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_fault = flt_q;
    assign rsp_paddr = pa_q;

    // R1: one response per request, one cycle later
    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_fault_zero_addr_r1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

    // R2: real mode passes the address untouched
    p_real_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !prot_en) |=>
            (rsp_fault == 2'd0 && rsp_paddr == $past(req_addr)));

    // R3: long-mode bypass never yields a protection fault
    p_bypass_no_gp_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && prot_en && long_act && cs_long) |=> (rsp_fault != 2'd1));

endmodule

// File: tb/tb_segxlat_top.sv
module tb_segxlat_top;

    localparam int ADDR_W = 32;
    localparam int NSEG   = 6;
    localparam int VPN_W  = 20;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     req_valid = 1'b0;
    logic [ADDR_W-1:0]        req_addr = '0;
    logic [3:0]               req_size = '0;
    logic                     req_write = 1'b0;
    logic                     req_exec = 1'b0;
    logic [2:0]               req_seg = '0;
    logic                     prot_en = 1'b0, paging_en = 1'b0;
    logic                     long_act = 1'b0, cs_long = 1'b0;
    logic [NSEG*ADDR_W-1:0]   seg_base = '0, seg_limit = '0;
    logic [NSEG-1:0]          seg_wr_ok = '0, seg_rd_ok = '0, seg_grow_down = '0;
    logic                     tbl_wr_en = 1'b0, tbl_inv_en = 1'b0;
    logic [VPN_W-1:0]         tbl_wr_vpn = '0, tbl_wr_pfn = '0, tbl_inv_vpn = '0;
    logic                     rsp_valid;
    logic [1:0]               rsp_fault;
    logic [ADDR_W-1:0]        rsp_paddr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    segxlat_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_exec(req_exec),
        .req_seg(req_seg), .prot_en(prot_en), .paging_en(paging_en),
        .long_act(long_act), .cs_long(cs_long), .seg_base(seg_base),
        .seg_limit(seg_limit), .seg_wr_ok(seg_wr_ok), .seg_rd_ok(seg_rd_ok),
        .seg_grow_down(seg_grow_down), .tbl_wr_en(tbl_wr_en),
        .tbl_wr_vpn(tbl_wr_vpn), .tbl_wr_pfn(tbl_wr_pfn),
        .tbl_inv_en(tbl_inv_en), .tbl_inv_vpn(tbl_inv_vpn),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    // mode = {prot_en, paging_en, long_act, cs_long}
    typedef struct packed {
        logic [3:0]  mode;
        logic [2:0]  seg;
        logic [31:0] addr;
        logic [3:0]  size;
        logic        wr;
        logic        ex;
        logic [1:0]  flt;
        logic [31:0] pa;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 3'd1, 32'h5000_0123, 4'd4, 1'b1, 1'b0, 2'd0, 32'h5000_0123, 4'd2},  // R2
        '{4'b0100, 3'd1, 32'h0000_1010, 4'd4, 1'b0, 1'b0, 2'd0, 32'h0000_1010, 4'd2},  // R2
        '{4'b1000, 3'd0, 32'h0000_1800, 4'd4, 1'b0, 1'b0, 2'd0, 32'h0000_1800, 4'd10}, // R10
        '{4'b1000, 3'd0, 32'h0000_1FFC, 4'd4, 1'b0, 1'b0, 2'd1, 32'h0,         4'd5},  // R5
        '{4'b1000, 3'd0, 32'h0000_1FFB, 4'd4, 1'b0, 1'b0, 2'd0, 32'h0000_1FFB, 4'd5},  // R5
        '{4'b1000, 3'd1, 32'h0000_1100, 4'd4, 1'b1, 1'b0, 2'd1, 32'h0,         4'd4},  // R4
        '{4'b1000, 3'd1, 32'h0000_1100, 4'd4, 1'b0, 1'b0, 2'd1, 32'h0,         4'd4},  // R4
        '{4'b1000, 3'd1, 32'h0000_1100, 4'd4, 1'b0, 1'b1, 2'd0, 32'h0000_1100, 4'd4},  // R4
        '{4'b1000, 3'd2, 32'h0000_0100, 4'd4, 1'b0, 1'b0, 2'd0, 32'h0000_0100, 4'd6},  // R6
        '{4'b1000, 3'd2, 32'h0000_2000, 4'd4, 1'b0, 1'b0, 2'd1, 32'h0,         4'd6},  // R6
        '{4'b1000, 3'd2, 32'h0000_9000, 4'd4, 1'b0, 1'b0, 2'd0, 32'h0000_9000, 4'd6},  // R6
        '{4'b1000, 3'd3, 32'h0000_1800, 4'd4, 1'b0, 1'b0, 2'd1, 32'h0,         4'd7},  // R7
        '{4'b1000, 3'd3, 32'h0000_2000, 4'd4, 1'b0, 1'b0, 2'd0, 32'h0000_2000, 4'd7},  // R7
        '{4'b1000, 3'd3, 32'h0000_0F00, 4'd4, 1'b0, 1'b0, 2'd0, 32'h0000_0F00, 4'd7},  // R7
        '{4'b1000, 3'd4, 32'h0000_0800, 4'd4, 1'b0, 1'b0, 2'd1, 32'h0,         4'd8},  // R8
        '{4'b1000, 3'd4, 32'h0000_4000, 4'd4, 1'b0, 1'b0, 2'd0, 32'h0000_4000, 4'd8},  // R8
        '{4'b1000, 3'd4, 32'h0000_7FFE, 4'd2, 1'b0, 1'b0, 2'd1, 32'h0,         4'd8},  // R8
        '{4'b1000, 3'd4, 32'h0000_7FFC, 4'd2, 1'b0, 1'b0, 2'd0, 32'h0000_7FFC, 4'd8},  // R8
        '{4'b1011, 3'd1, 32'h0000_3000, 4'd4, 1'b1, 1'b0, 2'd0, 32'h0000_3000, 4'd3},  // R3
        '{4'b1010, 3'd1, 32'h0000_3000, 4'd4, 1'b1, 1'b0, 2'd1, 32'h0,         4'd3},  // R3
        '{4'b1001, 3'd1, 32'h0000_3000, 4'd4, 1'b1, 1'b0, 2'd1, 32'h0,         4'd3},  // R3
        '{4'b1000, 3'd6, 32'h0000_0100, 4'd1, 1'b0, 1'b0, 2'd1, 32'h0,         4'd9},  // R9
        '{4'b1011, 3'd6, 32'h0000_0100, 4'd1, 1'b0, 1'b0, 2'd0, 32'h0000_0100, 4'd9},  // R9
        '{4'b1100, 3'd5, 32'h0000_1ABC, 4'd4, 1'b0, 1'b0, 2'd0, 32'hABCD_EABC, 4'd10}, // R10
        '{4'b1100, 3'd5, 32'h0000_2004, 4'd4, 1'b0, 1'b0, 2'd0, 32'h1234_5004, 4'd10}, // R10
        '{4'b1100, 3'd5, 32'h0000_3000, 4'd4, 1'b0, 1'b0, 2'd2, 32'h0,         4'd10}, // R10
        '{4'b1100, 3'd1, 32'h0000_1010, 4'd4, 1'b1, 1'b0, 2'd1, 32'h0,         4'd10}, // R10
        '{4'b1111, 3'd1, 32'h0000_2FFF, 4'd4, 1'b1, 1'b0, 2'd0, 32'h1234_5FFF, 4'd3}   // R3
    };

    task automatic check(input string rq, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic set_seg(input int s, input logic [31:0] b, input logic [31:0] l,
                           input logic w, input logic r, input logic d);
        seg_base[s*ADDR_W +: ADDR_W]  = b;
        seg_limit[s*ADDR_W +: ADDR_W] = l;
        seg_wr_ok[s]     = w;
        seg_rd_ok[s]     = r;
        seg_grow_down[s] = d;
    endtask

    // Called at a negedge; returns at the next negedge with the response visible
    task automatic cycle(input logic rq, input logic [3:0] mode, input logic [2:0] seg,
                         input logic [31:0] addr, input logic [3:0] size,
                         input logic wr, input logic ex,
                         input logic we, input logic [19:0] wv, input logic [19:0] wp,
                         input logic ie, input logic [19:0] iv);
        req_valid = rq;
        {prot_en, paging_en, long_act, cs_long} = mode;
        req_seg = seg; req_addr = addr; req_size = size;
        req_write = wr; req_exec = ex;
        tbl_wr_en = we; tbl_wr_vpn = wv; tbl_wr_pfn = wp;
        tbl_inv_en = ie; tbl_inv_vpn = iv;
        @(negedge clk);
        req_valid = 1'b0; tbl_wr_en = 1'b0; tbl_inv_en = 1'b0;
    endtask

    task automatic load(input logic [19:0] v, input logic [19:0] p);
        cycle(1'b0, 4'b1100, 3'd5, 32'h0, 4'd4, 1'b0, 1'b0, 1'b1, v, p, 1'b0, 20'h0);
    endtask

    task automatic flush(input logic [19:0] v);
        cycle(1'b0, 4'b1100, 3'd5, 32'h0, 4'd4, 1'b0, 1'b0, 1'b0, 20'h0, 20'h0, 1'b1, v);
    endtask

    task automatic look(input string rq, input logic [31:0] addr,
                        input logic [1:0] flt, input logic [31:0] pa);
        cycle(1'b1, 4'b1100, 3'd5, addr, 4'd4, 1'b0, 1'b0, 1'b0, 20'h0, 20'h0, 1'b0, 20'h0);
        check(rq, {rsp_fault, rsp_paddr}, {flt, pa});
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        set_seg(0, 32'h1000, 32'h1FFF,      1'b1, 1'b1, 1'b0);
        set_seg(1, 32'h1000, 32'h1FFF,      1'b0, 1'b0, 1'b0);
        set_seg(2, 32'h8000, 32'h0FFF,      1'b1, 1'b1, 1'b0);
        set_seg(3, 32'h1000, 32'h1FFF,      1'b1, 1'b1, 1'b1);
        set_seg(4, 32'h8000, 32'h0FFF,      1'b1, 1'b1, 1'b1);
        set_seg(5, 32'h0,    32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check("R1 reset state", {1'b0, rsp_valid, rsp_fault, rsp_paddr[29:0]}, 34'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {rsp_valid, rsp_fault, rsp_paddr[30:0]}, 34'h0);

        load(20'h00001, 20'hABCDE);   // slot 0
        load(20'h00002, 20'h12345);   // slot 1
        check("R1 idle no response", {33'h0, rsp_valid}, 34'h0);

        for (int i = 0; i < NV; i++) begin
            cycle(1'b1, VECS[i].mode, VECS[i].seg, VECS[i].addr, VECS[i].size,
                  VECS[i].wr, VECS[i].ex, 1'b0, 20'h0, 20'h0, 1'b0, 20'h0);
            checks++;
            if ({rsp_valid, rsp_fault, rsp_paddr} !== {1'b1, VECS[i].flt, VECS[i].pa}) begin
                fails++;
                $display("FAIL R%0d vector %0d actual=%b/%0d/%h expected=1/%0d/%h",
                         VECS[i].req, i, rsp_valid, rsp_fault, rsp_paddr,
                         VECS[i].flt, VECS[i].pa);
            end
        end
        @(negedge clk);
        check("R1 strobe drops", {33'h0, rsp_valid}, 34'h0);

        // R11: in-place update must not advance the pointer (still at slot 2)
        load(20'h00001, 20'h11111);
        for (int v = 16; v < 22; v++) load(20'(v), 20'h50000 + 20'(v));
        look("R11 in-place update kept", 32'h0000_1234, 2'd0, 32'h1111_1234);
        load(20'h00016, 20'h50016);   // wraps to slot 0, evicts page 1
        look("R11 wrap evicts slot 0", 32'h0000_1234, 2'd2, 32'h0);
        look("R11 slot 1 survives",    32'h0000_2234, 2'd0, 32'h1234_5234);
        look("R11 slot 7 filled",      32'h0001_5008, 2'd0, 32'h5001_5008);

        // R12: single-page flush
        flush(20'h00002);
        look("R12 flushed page misses", 32'h0000_2000, 2'd2, 32'h0);
        look("R12 other page kept",     32'h0001_0000, 2'd0, 32'h5001_0000);

        // R13: same-cycle write and lookup
        cycle(1'b1, 4'b1100, 3'd5, 32'h0002_0004, 4'd4, 1'b0, 1'b0,
              1'b1, 20'h00020, 20'h77777, 1'b0, 20'h0);
        check("R13 write same cycle sees old", {rsp_fault, rsp_paddr}, {2'd2, 32'h0});
        look("R13 write visible next", 32'h0002_0004, 2'd0, 32'h7777_7004);
        // R13: same-cycle flush and lookup
        cycle(1'b1, 4'b1100, 3'd5, 32'h0001_0000, 4'd4, 1'b0, 1'b0,
              1'b0, 20'h0, 20'h0, 1'b1, 20'h00010);
        check("R13 flush same cycle sees old", {rsp_fault, rsp_paddr}, {2'd0, 32'h5001_0000});
        look("R13 flush visible next", 32'h0001_0000, 2'd2, 32'h0);
        // R13: write and flush of one page together
        cycle(1'b0, 4'b1100, 3'd5, 32'h0, 4'd4, 1'b0, 1'b0,
              1'b1, 20'h00030, 20'h33333, 1'b1, 20'h00030);
        look("R13 write beats flush", 32'h0003_0010, 2'd0, 32'h3333_3010);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule